// File: doc/BRIEF.md
# Serial Memory Erase Command Slave

This block is the slave end of a serial memory's four-wire command port, operating in clock-polarity-0, clock-phase-0 timing. While the select line is low it collects an 8-bit opcode, most significant bit first, from the data input. It recognises three opcodes:

- set the write-enable latch;
- stream the status byte back to the host;
- erase the whole array.

The serial clock, select and data lines are first brought into the system clock domain, and all decisions are made in that domain.

An erase is accepted only when all of these hold:

- the write-enable latch is set;
- both protection bits are zero;
- no erase is already running;
- the select line returns high exactly after the eighth opcode bit.

Once accepted, a self-timed busy interval of a fixed number of system clocks begins. At the end of that interval every byte of a small on-block array becomes all ones, and the write-enable latch is cleared. A host polls the busy flag through the status opcode. A side read port shows the array contents so that the effect of an erase can be seen.

Top module: `spi_erase_ctrl`

## Requirements
- R1: After reset the status byte reads with busy and write-enable clear, the protection field equal to the PROT_RESET parameter, and bits 7:4 zero. Array byte i reads (i XOR 8'hA5).
- R2: Opcode 8'h06, followed by a select rise after exactly eight bits, sets the write-enable latch (status bit 1) when no erase is running.
- R3: After the 8 bits of opcode 8'h05, the status byte is driven on the serial output most significant bit first. Each bit changes after a falling serial clock edge. The layout is bit 0 busy, bit 1 write-enable, bits 3:2 protection, bits 7:4 zero.
- R4: The output enable stays low while an 8'h06 or 8'hC7 opcode is being shifted in.
- R5: Erase opcode 8'hC7 sent while the write-enable latch is clear changes neither the array nor the status.
- R6: An erase opcode ended by a select rise after 7 or after 9 bits is not executed. The array is unchanged, the busy flag stays clear and the latch keeps its value.
- R7: With a non-zero protection field, an erase opcode is ignored. The array is unchanged, the busy flag stays clear and the latch keeps its value.
- R8: An accepted erase sets the busy flag (status bit 0) for ERASE_CYCLES system clocks. During that time the array keeps its previous contents.
- R9: When the busy interval ends, every array byte reads 8'hFF and both the busy flag and the write-enable latch read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | High when spi_miso should be driven; pad is high-impedance otherwise |
| arr_addr | input | ADDR_W | Array byte address for the side read port |
| arr_data | output | 8 | Array byte at arr_addr |

## Verification
The bench builds two instances, both with DEPTH 16 and ERASE_CYCLES 600. The first has PROT_RESET 0, so it reaches the full path: latch set, accepted erase, busy flag polled mid-interval, and the array turning to all ones. The second has PROT_RESET 2'b01, so the protection field is non-zero, which is what lets the bench show an erase being refused with the latch set. The 600-cycle interval is long enough that a status read started right after the erase lands well inside the busy window.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_CERASE = 8'hC7;

    typedef struct packed {
        logic [3:0] rsvd;
        logic [1:0] prot;
        logic       wel;
        logic       wip;
    } status_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_RDSR,
        CMD_ERASE
    } cmd_e;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_fall;
        logic cs_rise;
        logic active;
        logic mosi;
    } spi_ev_t;

    function automatic cmd_e decode_op(input logic [7:0] op);
        cmd_e c;
        case (op)
            OP_WREN:   c = CMD_WREN;
            OP_RDSR:   c = CMD_RDSR;
            OP_CERASE: c = CMD_ERASE;
            default:   c = CMD_NONE;
        endcase
        return c;
    endfunction

    function automatic logic [7:0] reset_byte(input int unsigned idx);
        return 8'(idx) ^ 8'hA5;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_erase_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sck,
    input  logic    cs_n,
    input  logic    mosi,
    output spi_ev_t ev
);

    logic [STAGES-1:0] sck_p, cs_p, mosi_p;
    logic              sck_d, cs_d;
    logic              sck_s, cs_s;

    assign sck_s = sck_p[STAGES-1];
    assign cs_s  = cs_p[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
            sck_d  <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sck_p  <= {sck_p[STAGES-2:0], sck};
            cs_p   <= {cs_p[STAGES-2:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
            sck_d  <= sck_s;
            cs_d   <= cs_s;
        end
    end

    always_comb begin
        ev.sck_rise = sck_s & ~sck_d;
        ev.sck_fall = ~sck_s & sck_d;
        ev.cs_fall  = ~cs_s & cs_d;
        ev.cs_rise  = cs_s & ~cs_d;
        ev.active   = ~cs_s;
        ev.mosi     = mosi_p[STAGES-1];
    end

endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
    import spi_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  spi_ev_t    ev,
    output logic [7:0] op,
    output logic [3:0] bits,
    output logic       byte_done,
    output logic       frame_end,
    output logic       exact8
);

    localparam logic [3:0] SAT = 4'd9;

    always_ff @(posedge clk) begin
        if (rst) begin
            op        <= '0;
            bits      <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (ev.cs_fall) begin
                op   <= '0;
                bits <= '0;
            end else if (ev.sck_rise && ev.active) begin
                op <= {op[6:0], ev.mosi};
                if (bits < SAT) begin
                    bits <= bits + 4'd1;
                end
                byte_done <= (bits == 4'd7);
            end
        end
    end

    assign frame_end = ev.cs_rise;
    assign exact8    = (bits == 4'd8);

endmodule

// File: rtl/erase_engine.sv
module erase_engine
    import spi_erase_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int ERASE_CYCLES = 1000,
    localparam int ADDR_W      = $clog2(DEPTH),
    localparam int CNT_W       = $clog2(ERASE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [7:0]        rd_data
);

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= reset_byte(i);
            end
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(ERASE_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] <= 8'hFF;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign rd_data = ({1'b0, rd_addr} < (ADDR_W+1)'(DEPTH)) ? mem[rd_addr] : 8'h00;

    // R8: the interval counter never leaves its window
    a_r8_count_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CNT_W'(ERASE_CYCLES)));

    // R8: contents held while the interval runs
    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> ($stable(mem[0]) && $stable(mem[DEPTH-1])));

    // R9: the end of the interval leaves the array all ones
    a_r9_filled_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl
    import spi_erase_pkg::*;
#(
    parameter int         DEPTH        = 16,
    parameter int         ERASE_CYCLES = 1000,
    parameter logic [1:0] PROT_RESET   = 2'b00,
    parameter int         SYNC_STAGES  = 2,
    localparam int        ADDR_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_data
);

    spi_ev_t    ev;
    logic [7:0] rx_op;
    logic [3:0] rx_bits;
    logic       byte_done, frame_end, exact8;
    logic       busy, busy_d, start_erase;
    logic       wel_q;
    logic [1:0] prot_q;
    logic       tx_mode, miso_q;
    logic [2:0] tx_idx;
    status_t    stat;
    logic [7:0] stat_b;
    cmd_e       cmd;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sck  (spi_sck),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .ev   (ev)
    );

    spi_rx_frame u_rx (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .op        (rx_op),
        .bits      (rx_bits),
        .byte_done (byte_done),
        .frame_end (frame_end),
        .exact8    (exact8)
    );

    erase_engine #(.DEPTH(DEPTH), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start_erase),
        .rd_addr (arr_addr),
        .busy    (busy),
        .rd_data (arr_data)
    );

    assign cmd = decode_op(rx_op);

    always_comb begin
        stat.rsvd = 4'b0000;
        stat.prot = prot_q;
        stat.wel  = wel_q;
        stat.wip  = busy;
        stat_b    = stat;
    end

    assign start_erase = frame_end && exact8 && (cmd == CMD_ERASE) && !busy
                         && wel_q && (prot_q == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            prot_q <= PROT_RESET;
            busy_d <= 1'b0;
        end else begin
            busy_d <= busy;
            if (busy_d && !busy) begin
                wel_q <= 1'b0;
            end else if (frame_end && exact8 && cmd == CMD_WREN && !busy) begin
                wel_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_mode <= 1'b0;
            tx_idx  <= '0;
            miso_q  <= 1'b0;
        end else if (ev.cs_fall || ev.cs_rise) begin
            tx_mode <= 1'b0;
            tx_idx  <= '0;
        end else if (byte_done && ev.active && cmd == CMD_RDSR && !tx_mode) begin
            tx_mode <= 1'b1;
            tx_idx  <= '0;
        end else if (tx_mode && ev.sck_fall) begin
            miso_q <= stat_b[3'd7 - tx_idx];
            tx_idx <= tx_idx + 3'd1;
        end
    end

    assign spi_miso    = tx_mode ? miso_q : 1'b0;
    assign spi_miso_oe = tx_mode;

    // R7 and R8: a busy interval only starts with the latch set and no protection
    a_r8_start_needs_wel: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wel_q) && prot_q == 2'b00));

    // R6: a busy interval only follows a frame of exactly eight bits
    a_r6_start_on_exact8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(rx_bits) == 4'd8));

    // R9: the latch is cleared once the interval ends
    a_r9_wel_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> !wel_q);

    // R3 and R4: the output is only enabled after a status opcode
    a_r3_oe_after_rdsr: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_miso_oe) |-> (rx_op == OP_RDSR));

endmodule

// File: tb/tb_spi_erase_ctrl.sv
module tb_spi_erase_ctrl;

    localparam int DEPTH = 16;
    localparam int ECYC  = 600;
    localparam int HALF  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, mosi = 1'b0;
    logic       cs_a = 1'b1, cs_b = 1'b1;
    logic [3:0] addr = '0;
    logic       miso_a, oe_a, miso_b, oe_b;
    logic [7:0] data_a, data_b;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    int   exp_wel  [2];
    int   exp_prot [2];
    int   erase_end[2];
    int   exp_mem  [2][DEPTH];
    int   done_flag = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    spi_erase_ctrl #(.DEPTH(DEPTH), .ERASE_CYCLES(ECYC), .PROT_RESET(2'b00)) dut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_a), .spi_mosi(mosi),
        .spi_miso(miso_a), .spi_miso_oe(oe_a), .arr_addr(addr), .arr_data(data_a));

    spi_erase_ctrl #(.DEPTH(DEPTH), .ERASE_CYCLES(ECYC), .PROT_RESET(2'b01)) dut_p (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_b), .spi_mosi(mosi),
        .spi_miso(miso_b), .spi_miso_oe(oe_b), .arr_addr(addr), .arr_data(data_b));

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int w);
        if (erase_end[w] != 0 && cyc >= erase_end[w]) begin
            erase_end[w] = 0;
            exp_wel[w]   = 0;
            for (int i = 0; i < DEPTH; i++) exp_mem[w][i] = 8'hFF;
        end
    endtask

    function automatic int model_status(input int w);
        return (exp_prot[w] << 2) | (exp_wel[w] << 1) | ((erase_end[w] != 0) ? 1 : 0);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cs(input int w, input logic v);
        if (w == 0) cs_a = v; else cs_b = v;
    endtask

    task automatic send_cmd(input int w, input logic [7:0] op, input int nbits, input string req);
        int oe_seen = 0;
        settle(w);
        set_cs(w, 1'b0);
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? op[7-i] : 1'b0;
            wait_clk(HALF);
            if ((w == 0 ? oe_a : oe_b) == 1'b1) oe_seen = 1;
            sck = 1'b1;
            wait_clk(HALF);
            if ((w == 0 ? oe_a : oe_b) == 1'b1) oe_seen = 1;
            sck = 1'b0;
        end
        wait_clk(HALF);
        chk({req, " R4 output enable during opcode"}, oe_seen, 0);
        set_cs(w, 1'b1);
        if (nbits == 8 && erase_end[w] == 0) begin
            if (op == 8'h06) exp_wel[w] = 1;
            if (op == 8'hC7 && exp_wel[w] == 1 && exp_prot[w] == 0)
                erase_end[w] = cyc + ECYC + 6;
        end
        wait_clk(2 * HALF);
    endtask

    task automatic read_status(input int w, input string req);
        logic [7:0] got;
        int expv;
        settle(w);
        expv = model_status(w);
        set_cs(w, 1'b0);
        wait_clk(HALF);
        for (int i = 0; i < 8; i++) begin
            mosi = 8'h05 >> (7 - i);
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        for (int i = 0; i < 8; i++) begin
            mosi = 1'b0;
            wait_clk(HALF);
            got[7-i] = (w == 0) ? miso_a : miso_b;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        set_cs(w, 1'b1);
        wait_clk(2 * HALF);
        chk({req, " R3 status byte"}, int'(got), expv);
    endtask

    task automatic check_array(input int w, input string req);
        settle(w);
        for (int i = 0; i < DEPTH; i++) begin
            addr = 4'(i);
            wait_clk(1);
            chk(req, int'(w == 0 ? data_a : data_b), exp_mem[w][i]);
        end
    endtask

    task automatic report;
        if (done_flag == 0) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int w = 0; w < 2; w++) begin
            exp_wel[w]   = 0;
            erase_end[w] = 0;
            for (int i = 0; i < DEPTH; i++) exp_mem[w][i] = (i ^ 8'hA5);
        end
        exp_prot[0] = 0;
        exp_prot[1] = 1;
        wait_clk(6);
        rst = 1'b0;
        wait_clk(4);

        // R1 reset state
        chk("R1 output enable idle", int'(oe_a), 0);
        read_status(0, "R1 reset status");
        read_status(1, "R1 reset status protected");
        check_array(0, "R1 reset array");
        check_array(1, "R1 reset array protected");

        // R5 erase without latch
        send_cmd(0, 8'hC7, 8, "R5");
        read_status(0, "R5 status after refused erase");
        check_array(0, "R5 array untouched");

        // R2 latch set
        send_cmd(0, 8'h06, 8, "R2");
        read_status(0, "R2 latch set");

        // R6 wrong bit counts
        send_cmd(0, 8'hC7, 7, "R6 seven bits");
        read_status(0, "R6 after seven bits");
        send_cmd(0, 8'hC7, 9, "R6 nine bits");
        read_status(0, "R6 after nine bits");
        check_array(0, "R6 array untouched");

        // R8 accepted erase
        send_cmd(0, 8'hC7, 8, "R8");
        read_status(0, "R8 busy flag mid interval");
        check_array(0, "R8 array held while busy");

        // R9 completion
        wait_clk(ECYC + 100);
        read_status(0, "R9 status after interval");
        check_array(0, "R9 array all ones");

        // R7 protection refuses the erase
        send_cmd(1, 8'h06, 8, "R7 latch");
        read_status(1, "R7 latch set protected");
        send_cmd(1, 8'hC7, 8, "R7 erase");
        read_status(1, "R7 status after refused erase");
        wait_clk(ECYC + 100);
        check_array(1, "R7 array untouched");

        report();
    end

endmodule